// File: doc/BRIEF.md
# Task Operand Dependency Tracker

This block sits between a task generator and a pool of worker processors. Task descriptors arrive in program order, each naming up to three memory objects by base address and saying for each whether the task reads it, writes it, or both. A fully associative version table remembers, for every address still being written, which in-flight task produces its newest version. At decode the block looks up each operand, turns every read operand with a live producer into a wait bit, and parks the task in a station slot whose index becomes the task identifier. Addresses are opaque tags; the block never touches data.

A parked task is offered for dispatch once every producer it waits on has completed. Dispatch picks the lowest ready identifier, and completions may arrive in any order. Tasks that only write an address never wait. The writer becomes the new latest version, so reads and writes of older versions that are still in flight do not hold it back. A separate query port reports whether one address still has a producer in flight. Only committed tasks are ever presented, so there is no flush path.

Both streams are valid/ready. A descriptor is taken on a cycle where `dec_valid` and `dec_ready` are both high, and the source holds it unchanged until then. A dispatch offer, once raised, keeps the same `disp_id` until `disp_ready` takes it. Completion and query are plain pins.

Top module: `dt_task_tracker`

## Requirements
- R1: After reset `dec_ready` is 1, `disp_valid` is 0 and `wq_ready` is 1 for any address.
- R2: Operand kind is two bits per operand, operand n at `dec_kind[2n+1:2n]`: 0 unused, 1 read, 2 write, 3 read-write. Bit 0 set means the task waits for the address's latest in-flight producer. Bit 1 set makes the task the address's latest producer.
- R3: An accepted descriptor gets the lowest free station slot as its identifier, shown on `dec_id` during the accepting cycle.
- R4: `disp_valid` is high only for a task whose producers have all completed. Among ready tasks the lowest identifier is offered. While an offer stands unaccepted, `disp_id` does not change.
- R5: A write-only operand never creates a wait, even when earlier tasks still read or write that address; the new writer replaces the older version.
- R6: `done_valid` with `done_id` retires that dispatched task and frees its slot. A version-table entry is released only if it still names that task as the latest producer.
- R7: `wq_ready` for `wq_addr` goes high in the cycle after the address's latest producer completes, whatever other tasks remain in flight.
- R8: `dec_ready` is low when no station slot is free or when fewer than three version-table entries are free.
- R9: A read of an address whose producer completes in the same cycle as the decode creates no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Descriptor present |
| dec_ready | output | 1 | Descriptor can be taken |
| dec_addr | input | NOPS*ADDR_W | Operand base addresses, operand n at bits [n*ADDR_W +: ADDR_W] |
| dec_kind | input | 2*NOPS | Operand kinds, two bits per operand (R2) |
| dec_id | output | ID_W | Identifier given to the descriptor taken this cycle |
| disp_valid | output | 1 | A ready task is offered |
| disp_ready | input | 1 | Worker takes the offered task |
| disp_id | output | ID_W | Identifier of the offered task |
| done_valid | input | 1 | A dispatched task has completed |
| done_id | input | ID_W | Identifier of the completed task |
| wq_addr | input | ADDR_W | Address being waited on |
| wq_ready | output | 1 | No in-flight producer for wq_addr |

## Verification
The assertions take for granted that `done_id` always names a dispatched and not yet completed task, that at most one completion arrives per cycle, that the three operand addresses of one descriptor are distinct, and that a stalled descriptor is held. The bench draws every completion from the dispatched set of its own model, builds operand addresses from fixed distinct offsets, and re-presents a stalled descriptor unchanged. Directed runs build read-after-write chains, renamed writes, completion during decode and both kinds of backpressure. A long random run then mixes kinds, stalls and out-of-order completion over a small address pool.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic [1:0] {SLOT_FREE, SLOT_WAIT, SLOT_ISSUED} slot_e;
  localparam logic [1:0] KIND_NONE  = 2'd0;
  localparam logic [1:0] KIND_RD    = 2'd1;
  localparam logic [1:0] KIND_WR    = 2'd2;
  localparam logic [1:0] KIND_RDWR  = 2'd3;
endpackage

// File: rtl/dt_lowest.sv
module dt_lowest #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/dt_version_table.sv
module dt_version_table #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 16,
  parameter int NOPS   = 3,
  parameter int ID_W   = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NOPS-1:0][ADDR_W-1:0]      lk_addr,
  output logic [NOPS-1:0]                  lk_hit,
  output logic [NOPS-1:0][ID_W-1:0]        lk_prod,
  input  logic                             wr_en,
  input  logic [NOPS-1:0]                  wr_op,
  input  logic [ID_W-1:0]                  wr_id,
  input  logic                             rel_en,
  input  logic [ID_W-1:0]                  rel_id,
  input  logic [ADDR_W-1:0]                q_addr,
  output logic                             q_busy,
  output logic                             room
);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0]             e_v, n_v, avail;
  logic [DEPTH-1:0][ADDR_W-1:0] e_addr, n_addr;
  logic [DEPTH-1:0][ID_W-1:0]   e_prod, n_prod;
  logic [NOPS-1:0][IW-1:0]      lk_idx;
  logic [DEPTH-1:0]             qmatch;
  logic                         alloc_got;
  int unsigned                  free_cnt;

  always_comb begin
    for (int o = 0; o < NOPS; o++) begin
      lk_hit[o]  = 1'b0;
      lk_prod[o] = '0;
      lk_idx[o]  = '0;
      for (int e = 0; e < DEPTH; e++) begin
        if (e_v[e] && e_addr[e] == lk_addr[o]) begin
          lk_hit[o]  = 1'b1;
          lk_prod[o] = e_prod[e];
          lk_idx[o]  = IW'(e);
        end
      end
    end
  end

  always_comb begin
    free_cnt = 0;
    for (int e = 0; e < DEPTH; e++) begin
      qmatch[e] = e_v[e] && (e_addr[e] == q_addr);
      if (!e_v[e]) free_cnt = free_cnt + 1;
    end
  end
  assign q_busy = |qmatch;
  assign room   = (free_cnt >= NOPS);

  always_comb begin
    n_v       = e_v;
    n_addr    = e_addr;
    n_prod    = e_prod;
    avail     = ~e_v;
    alloc_got = 1'b0;
    if (rel_en) begin
      for (int e = 0; e < DEPTH; e++) begin
        if (e_v[e] && e_prod[e] == rel_id) n_v[e] = 1'b0;
      end
    end
    if (wr_en) begin
      for (int o = 0; o < NOPS; o++) begin
        if (wr_op[o]) begin
          if (lk_hit[o]) begin
            n_v[lk_idx[o]]    = 1'b1;
            n_prod[lk_idx[o]] = wr_id;
          end else begin
            alloc_got = 1'b0;
            for (int e = 0; e < DEPTH; e++) begin
              if (!alloc_got && avail[e]) begin
                alloc_got = 1'b1;
                avail[e]  = 1'b0;
                n_v[e]    = 1'b1;
                n_addr[e] = lk_addr[o];
                n_prod[e] = wr_id;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v    <= '0;
      e_addr <= '0;
      e_prod <= '0;
    end else begin
      e_v    <= n_v;
      e_addr <= n_addr;
      e_prod <= n_prod;
    end
  end

  AST_ONE_VERSION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(qmatch) <= 1); // R5
  AST_WRITE_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> room); // R8
endmodule

// File: rtl/dt_station.sv
module dt_station
  import dt_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ID_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [DEPTH-1:0] ins_mask,
  input  logic             rel_en,
  input  logic [ID_W-1:0]  rel_id,
  input  logic             disp_ready,
  output logic             has_free,
  output logic [ID_W-1:0]  free_id,
  output logic             disp_valid,
  output logic [ID_W-1:0]  disp_id
);
  slot_e                       st [DEPTH];
  logic [DEPTH-1:0][DEPTH-1:0] wmask;
  logic [DEPTH-1:0]            free_req, rdy_req;
  logic                        rdy_found, hold_v, fire;
  logic [ID_W-1:0]             rdy_idx, hold_id;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      free_req[i] = (st[i] == SLOT_FREE);
      rdy_req[i]  = (st[i] == SLOT_WAIT) && (wmask[i] == '0);
    end
  end

  dt_lowest #(.N(DEPTH), .W(ID_W)) i_free_pick (
    .req(free_req), .found(has_free), .idx(free_id));
  dt_lowest #(.N(DEPTH), .W(ID_W)) i_rdy_pick (
    .req(rdy_req), .found(rdy_found), .idx(rdy_idx));

  assign disp_valid = hold_v | rdy_found;
  assign disp_id    = hold_v ? hold_id : rdy_idx;
  assign fire       = disp_valid && disp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st[i] <= SLOT_FREE;
      wmask   <= '0;
      hold_v  <= 1'b0;
      hold_id <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_en && free_id == ID_W'(i)) begin
          st[i]    <= SLOT_WAIT;
          wmask[i] <= ins_mask;
        end else begin
          if (rel_en) wmask[i][rel_id] <= 1'b0;
          if (rel_en && rel_id == ID_W'(i)) st[i] <= SLOT_FREE;
          else if (fire && disp_id == ID_W'(i)) st[i] <= SLOT_ISSUED;
        end
      end
      hold_v  <= disp_valid && !disp_ready;
      hold_id <= disp_id;
    end
  end

  AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready |=> disp_valid && disp_id == $past(disp_id)); // R4
  AST_OFFER_DEPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> st[disp_id] == SLOT_WAIT && wmask[disp_id] == '0); // R4
  AST_RETIRE_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> st[rel_id] == SLOT_ISSUED); // R6
  AST_INSERT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> st[free_id] == SLOT_FREE); // R3
endmodule

// File: rtl/dt_task_tracker.sv
module dt_task_tracker #(
  parameter int ADDR_W    = 16,
  parameter int NOPS      = 3,
  parameter int SLOTS     = 16,
  parameter int TBL_DEPTH = 16,
  localparam int ID_W     = $clog2(SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dec_valid,
  output logic                   dec_ready,
  input  logic [NOPS*ADDR_W-1:0] dec_addr,
  input  logic [2*NOPS-1:0]      dec_kind,
  output logic [ID_W-1:0]        dec_id,
  output logic                   disp_valid,
  input  logic                   disp_ready,
  output logic [ID_W-1:0]        disp_id,
  input  logic                   done_valid,
  input  logic [ID_W-1:0]        done_id,
  input  logic [ADDR_W-1:0]      wq_addr,
  output logic                   wq_ready
);
  logic [NOPS-1:0][ADDR_W-1:0] op_addr;
  logic [NOPS-1:0]             op_rd, op_wr, lk_hit;
  logic [NOPS-1:0][ID_W-1:0]   lk_prod;
  logic [SLOTS-1:0]            dmask;
  logic                        has_free, room, accept, q_busy;

  assign op_addr = dec_addr;
  for (genvar o = 0; o < NOPS; o++) begin : g_kind
    assign op_rd[o] = dec_kind[2*o];
    assign op_wr[o] = dec_kind[2*o+1];
  end

  assign dec_ready = has_free && room;
  assign accept    = dec_valid && dec_ready;
  assign wq_ready  = !q_busy;

  always_comb begin
    dmask = '0;
    for (int o = 0; o < NOPS; o++) begin
      if (op_rd[o] && lk_hit[o] && !(done_valid && lk_prod[o] == done_id))
        dmask[lk_prod[o]] = 1'b1;
    end
  end

  dt_version_table #(.ADDR_W(ADDR_W), .DEPTH(TBL_DEPTH), .NOPS(NOPS), .ID_W(ID_W)) i_table (
    .clk(clk), .rst_n(rst_n),
    .lk_addr(op_addr), .lk_hit(lk_hit), .lk_prod(lk_prod),
    .wr_en(accept), .wr_op(op_wr), .wr_id(dec_id),
    .rel_en(done_valid), .rel_id(done_id),
    .q_addr(wq_addr), .q_busy(q_busy), .room(room));

  dt_station #(.DEPTH(SLOTS), .ID_W(ID_W)) i_station (
    .clk(clk), .rst_n(rst_n),
    .ins_en(accept), .ins_mask(dmask),
    .rel_en(done_valid), .rel_id(done_id),
    .disp_ready(disp_ready),
    .has_free(has_free), .free_id(dec_id),
    .disp_valid(disp_valid), .disp_id(disp_id));

  AST_NO_SELF_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !dmask[dec_id]); // R2
  AST_DONE_CLEARS_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !accept && lk_hit[0] && lk_prod[0] == done_id
      |=> $stable(op_addr[0]) |-> !lk_hit[0]); // R7
endmodule

// File: tb/test_dt_task_tracker.sv
module test_dt_task_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NO = 3;
  localparam int SL = 16;
  localparam int TD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            dec_valid = 1'b0;
  logic [NO*AW-1:0] dec_addr = '0;
  logic [2*NO-1:0] dec_kind = '0;
  logic            dec_ready;
  logic [3:0]      dec_id;
  logic            disp_valid;
  logic            disp_ready = 1'b0;
  logic [3:0]      disp_id;
  logic            done_valid = 1'b0;
  logic [3:0]      done_id = '0;
  logic [AW-1:0]   wq_addr = '0;
  logic            wq_ready;

  dt_task_tracker i_dt_task_tracker (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_addr(dec_addr),
    .dec_kind(dec_kind), .dec_id(dec_id),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_id(disp_id),
    .done_valid(done_valid), .done_id(done_id),
    .wq_addr(wq_addr), .wq_ready(wq_ready));

  // reference model: 0 free, 1 waiting, 2 dispatched
  int              m_st [SL];
  logic [SL-1:0]   m_dep [SL];
  int              m_tbl [int];
  bit              m_hv;
  int              m_hid;
  bit              m_acc;
  int              nchk = 0;
  int              nerr = 0;
  string           tag = "R1";

  task automatic chk(string req, int got, int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s (%s): actual %0d expected %0d", req, tag, got, exp);
    end
  endtask

  task automatic step();
    int e_rdy, e_id, e_dv, e_did, nfree, e_wq;
    int dq[$];
    logic [SL-1:0] d;
    #1;
    nfree = 0; e_id = -1;
    for (int i = 0; i < SL; i++) if (m_st[i] == 0) begin
      nfree++;
      if (e_id < 0) e_id = i;
    end
    e_rdy = (nfree > 0 && (TD - m_tbl.num()) >= NO) ? 1 : 0;
    e_dv = 0; e_did = 0;
    if (m_hv) begin e_dv = 1; e_did = m_hid; end
    else for (int i = 0; i < SL; i++)
      if (e_dv == 0 && m_st[i] == 1 && m_dep[i] == '0) begin e_dv = 1; e_did = i; end
    e_wq = m_tbl.exists(int'(wq_addr)) ? 0 : 1;
    chk("R8 dec_ready", int'(dec_ready), e_rdy);
    if (e_rdy == 1) chk("R3 dec_id", int'(dec_id), e_id);
    chk("R4 disp_valid", int'(disp_valid), e_dv);
    if (e_dv == 1) chk("R4 disp_id", int'(disp_id), e_did);
    chk("R7 wq_ready", int'(wq_ready), e_wq);
    if (done_valid) begin
      m_st[done_id] = 0;
      for (int i = 0; i < SL; i++) m_dep[i][done_id] = 1'b0;
      foreach (m_tbl[k]) if (m_tbl[k] == int'(done_id)) dq.push_back(k);
      foreach (dq[j]) m_tbl.delete(dq[j]);
    end
    m_acc = dec_valid && (e_rdy == 1);
    if (m_acc) begin
      d = '0;
      for (int o = 0; o < NO; o++)
        if (dec_kind[2*o] && m_tbl.exists(int'(dec_addr[o*AW +: AW])))
          d[m_tbl[int'(dec_addr[o*AW +: AW])]] = 1'b1;
      for (int o = 0; o < NO; o++)
        if (dec_kind[2*o+1]) m_tbl[int'(dec_addr[o*AW +: AW])] = e_id;
      m_st[e_id] = 1;
      m_dep[e_id] = d;
    end
    if (e_dv == 1 && disp_ready) begin m_st[e_did] = 2; m_hv = 0; end
    else begin m_hv = (e_dv == 1); m_hid = e_did; end
    @(posedge clk);
  endtask

  task automatic cyc(bit dv, logic [47:0] a, logic [5:0] k, bit dr, bit cv, int cid,
                     logic [15:0] q);
    @(negedge clk);
    dec_valid = dv; dec_addr = a; dec_kind = k; disp_ready = dr;
    done_valid = cv; done_id = cid[3:0]; wq_addr = q;
    step();
  endtask

  task automatic drain();
    repeat (60) begin
      int c;
      c = -1;
      for (int i = 0; i < SL; i++) if (m_st[i] == 2 && c < 0) c = i;
      cyc(1'b0, '0, '0, 1'b1, c >= 0, (c < 0) ? 0 : c, 16'h0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [47:0] ra;
    logic [5:0]  rk;
    bit          pend;
    for (int i = 0; i < SL; i++) begin m_st[i] = 0; m_dep[i] = '0; end
    m_hv = 0; m_hid = 0; pend = 0; ra = '0; rk = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset dec_ready", int'(dec_ready), 1);
    chk("R1 reset disp_valid", int'(disp_valid), 0);
    chk("R1 reset wq_ready", int'(wq_ready), 1);
    @(posedge clk);

    // R2: read-after-write chain, renamed writer alongside (R5)
    tag = "R2 chain";
    cyc(1, {32'h0, 16'h0100}, 6'b000010, 0, 0, 0, 16'h0100);
    cyc(1, {32'h0, 16'h0100}, 6'b000001, 0, 0, 0, 16'h0100);
    tag = "R5 rename";
    cyc(1, {32'h0, 16'h0100}, 6'b000010, 1, 0, 0, 16'h0100);
    cyc(0, '0, '0, 1, 0, 0, 16'h0100);
    tag = "R2 chain";
    cyc(0, '0, '0, 1, 1, 0, 16'h0100);
    cyc(0, '0, '0, 1, 1, 2, 16'h0100);
    cyc(0, '0, '0, 1, 1, 1, 16'h0100);
    drain();

    // R9: completion during decode of a read-write consumer
    tag = "R9 same cycle";
    cyc(1, {32'h0, 16'h0200}, 6'b000010, 1, 0, 0, 16'h0200);
    cyc(0, '0, '0, 1, 0, 0, 16'h0200);
    cyc(1, {32'h0, 16'h0200}, 6'b000011, 0, 1, 0, 16'h0200);
    cyc(0, '0, '0, 0, 0, 0, 16'h0200);
    drain();

    // R6 / R7: older writer completes first, entry kept for newer one
    tag = "R6 release";
    cyc(1, {32'h0, 16'h0300}, 6'b000010, 1, 0, 0, 16'h0300);
    cyc(1, {32'h0, 16'h0300}, 6'b000010, 1, 0, 0, 16'h0300);
    cyc(1, {32'h0, 16'h0400}, 6'b000010, 1, 0, 0, 16'h0300);
    cyc(0, '0, '0, 1, 1, 0, 16'h0300);
    cyc(0, '0, '0, 1, 0, 0, 16'h0300);
    tag = "R7 query";
    cyc(0, '0, '0, 1, 1, 1, 16'h0300);
    cyc(0, '0, '0, 1, 0, 0, 16'h0300);
    cyc(0, '0, '0, 1, 0, 0, 16'h0400);
    drain();

    // R8: station full, then table short of room
    tag = "R8 station full";
    for (int n = 0; n < SL + 3; n++)
      cyc(1, {32'h0, 16'h0500}, 6'b000001, 0, 0, 0, 16'h0500);
    drain();
    tag = "R8 table full";
    for (int n = 0; n < 7; n++)
      cyc(1, {16'h0702 + 16'(3*n), 16'h0701 + 16'(3*n), 16'h0700 + 16'(3*n)},
          6'b101010, 0, 0, 0, 16'h0700);
    drain();

    // R4: random mix, out-of-order completion
    tag = "R4 random";
    for (int n = 0; n < 4000; n++) begin
      int b, c, cnt;
      bit dv;
      if (!pend) begin
        b  = $urandom % 8;
        ra = {16'h0600 + 16'((b + 5) % 8), 16'h0600 + 16'((b + 3) % 8), 16'h0600 + 16'(b)};
        rk = 6'($urandom);
        dv = ($urandom % 10) < 7;
      end else dv = 1;
      c = -1; cnt = 0;
      for (int i = 0; i < SL; i++) if (m_st[i] == 2) begin
        cnt++;
        if (($urandom % cnt) == 0) c = i;
      end
      if (($urandom % 2) == 0) c = -1;
      cyc(dv, ra, rk, ($urandom % 4) != 0, c >= 0, (c < 0) ? 0 : c,
          16'h0600 + 16'($urandom % 8));
      pend = dv && !m_acc;
    end
    tag = "R6 final drain";
    drain();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule